// File: doc/BRIEF.md
# Compact Floating-Point Multiply and Power-of-Two Scaling Unit

This unit multiplies two numbers held in a compact floating-point word. The word has a sign, a five-bit exponent with an offset of 15, and a fraction whose width is a parameter. It also scales one operand up or down by a power of two. A scaling operation only moves the exponent, so it costs a single small adder instead of a multiplier. Subnormal values are not supported: a subnormal input is read as zero and a result that would be subnormal becomes zero. The significand product is truncated, never rounded.

A caller presents the operands, a signed shift count and an opcode, and raises `start` for one cycle. The unit raises `done` for one cycle when the result is ready. The `LATENCY` parameter sets whether this takes one cycle or two. The two-cycle form is not pipelined: it takes no new request while a job is in flight. The result stays on `result` until the next job finishes.

The controller has three states. IDLE waits for work. HOLD is the middle cycle of a two-cycle job, with the operands registered. DONE shows a finished result. The transitions are:
- IDLE→HOLD, or IDLE→DONE in the one-cycle form, on `start`.
- HOLD→DONE always.
- DONE→HOLD, or DONE→DONE in the one-cycle form, on `start`.
- DONE→IDLE without `start`.
- IDLE→IDLE without `start`.

Top module: `sfmul_unit`

## Requirements
- R1: A word is {sign (MSB), exponent (5 bits, offset 15), fraction (FRAC_W bits, LSBs)}. FRAC_W is a parameter (default 10; 7 is also supported). A word with exponent 31 is infinity when its fraction is zero and NaN otherwise. Opcode 0 multiplies `a` by `b`. Opcode 1 scales `a` by 2^shamt. Opcode 2 scales `a` by 2^-shamt. Opcode 3 behaves as opcode 0.
- R2: `done` rises exactly LATENCY cycles after an accepted `start` and lasts one cycle, unless another job is accepted in that cycle.
- R3: With LATENCY=2, a `start` in the middle (HOLD) cycle is ignored. It produces no extra `done` and no change of result.
- R4: For normal finite operands, a multiply gives sign = sign_a XOR sign_b. The exponent is e_a+e_b-15, plus 1 when the significand product is at least 2.0. The fraction is the product truncated to FRAC_W bits.
- R5: An operand with exponent 0 counts as zero, whatever its fraction. A zero times a finite value gives zero carrying the XOR sign.
- R6: Infinity times a non-zero non-NaN value gives infinity with the XOR sign. A result exponent of 31 or more gives infinity with the result sign.
- R7: A result exponent of 0 or less gives a zero with the result sign. No result is ever subnormal.
- R8: Any NaN operand, and zero times infinity, give the canonical NaN: sign 0, exponent 31, fraction MSB 1 and all other fraction bits 0.
- R9: Scaling keeps the sign and fraction of `a` and adds (opcode 1) or subtracts (opcode 2) the signed `shamt` from its exponent. The R6 and R7 range rules apply. A NaN `a` gives the canonical NaN. An infinite or zero `a` passes through with its sign.
- R10: `result` changes only in cycles where `done` is high.
- R11: During reset, `done` is 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request a job this cycle |
| op | input | 2 | Opcode (R1) |
| a | input | FRAC_W+6 | First operand; the value scaled by opcodes 1 and 2 |
| b | input | FRAC_W+6 | Second operand for a multiply |
| shamt | input | SH_W | Signed power-of-two count for scaling |
| done | output | 1 | One-cycle completion pulse |
| result | output | FRAC_W+6 | Product or scaled value |

## Verification
The properties assume that `start` is never unknown once reset is released. In the one-cycle form they also assume that operands are valid in the cycle `start` is high; in the two-cycle form operands only need to be valid in the accepting cycle. The stimulus changes every input at the falling edge and holds it through the next rising edge. It keeps `shamt` within its signed width. Only the deliberate test of R3 drives `start` during the HOLD cycle.

// File: rtl/sfm_pkg.sv
package sfm_pkg;
    localparam int EXP_W    = 5;
    localparam int EXP_BIAS = 15;
    localparam int EXP_TOP  = (1 << EXP_W) - 1;

    typedef enum logic [1:0] {
        OP_MUL  = 2'd0,
        OP_UP   = 2'd1,
        OP_DOWN = 2'd2,
        OP_ALT  = 2'd3
    } sfm_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_HOLD = 2'd1,
        S_DONE = 2'd2
    } sfm_state_e;

    typedef struct packed {
        logic is_zero;
        logic is_inf;
        logic is_nan;
    } sfm_class_t;
endpackage

// File: rtl/sfm_classify.sv
module sfm_classify
    import sfm_pkg::*;
#(
    parameter int FRAC_W = 10
) (
    input  logic [FRAC_W+EXP_W:0] val,
    output sfm_class_t            cls,
    output logic [FRAC_W:0]       sig,
    output logic [EXP_W-1:0]      exp_o
);
    logic [FRAC_W-1:0] frac;
    logic              exp_all0;
    logic              exp_all1;

    assign exp_o    = val[FRAC_W +: EXP_W];
    assign frac     = val[FRAC_W-1:0];
    assign exp_all0 = (exp_o == '0);
    assign exp_all1 = (exp_o == '1);

    // subnormals are read as zero; the hidden one is always prepended
    assign cls.is_zero = exp_all0;
    assign cls.is_inf  = exp_all1 && (frac == '0);
    assign cls.is_nan  = exp_all1 && (frac != '0);
    assign sig         = {1'b1, frac};
endmodule

// File: rtl/sfm_datapath.sv
module sfm_datapath
    import sfm_pkg::*;
#(
    parameter int FRAC_W = 10,
    parameter int SH_W   = 6
) (
    input  logic [1:0]              op,
    input  logic [FRAC_W+EXP_W:0]   a,
    input  logic [FRAC_W+EXP_W:0]   b,
    input  logic signed [SH_W-1:0]  shamt,
    output logic [FRAC_W+EXP_W:0]   res
);
    localparam int W  = FRAC_W + EXP_W + 1;
    localparam int PW = 2 * (FRAC_W + 1);
    localparam int CW = EXP_W + 4;
    localparam logic signed [CW-1:0] BIAS_C = CW'(EXP_BIAS);
    localparam logic signed [CW-1:0] TOP_C  = CW'(EXP_TOP);
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    sfm_op_e op_e;
    assign op_e = sfm_op_e'(op);

    logic [W-1:0]       opnd [2];
    sfm_class_t         cls  [2];
    logic [FRAC_W:0]    sig  [2];
    logic [EXP_W-1:0]   ex   [2];

    assign opnd[0] = a;
    assign opnd[1] = b;

    for (genvar g = 0; g < 2; g++) begin : g_cls
        sfm_classify #(.FRAC_W(FRAC_W)) u_cls (
            .val   (opnd[g]),
            .cls   (cls[g]),
            .sig   (sig[g]),
            .exp_o (ex[g])
        );
    end

    // significand product and its normalisation
    logic [PW-1:0]     prod;
    logic              norm;
    logic [FRAC_W-1:0] frac_m;

    assign prod   = sig[0] * sig[1];
    assign norm   = prod[PW-1];
    assign frac_m = norm ? prod[PW-2 -: FRAC_W] : prod[PW-3 -: FRAC_W];

    // exponent paths
    logic signed [CW-1:0] ex0_w, ex1_w, sh_w, e_mul, e_scl;

    assign ex0_w = {{(CW-EXP_W){1'b0}}, ex[0]};
    assign ex1_w = {{(CW-EXP_W){1'b0}}, ex[1]};
    assign sh_w  = {{(CW-SH_W){shamt[SH_W-1]}}, shamt};
    assign e_mul = ex0_w + ex1_w - BIAS_C + {{(CW-1){1'b0}}, norm};
    assign e_scl = (op_e == OP_UP) ? (ex0_w + sh_w) : (ex0_w - sh_w);

    logic                 scaling;
    logic                 s_res;
    logic                 f_nan, f_inf, f_zero;
    logic signed [CW-1:0] e_fin;
    logic [FRAC_W-1:0]    f_fin;

    assign scaling = (op_e == OP_UP) || (op_e == OP_DOWN);

    always_comb begin
        if (scaling) begin
            s_res  = a[W-1];
            f_nan  = cls[0].is_nan;
            f_inf  = cls[0].is_inf;
            f_zero = cls[0].is_zero;
            e_fin  = e_scl;
            f_fin  = sig[0][FRAC_W-1:0];
        end else begin
            s_res  = a[W-1] ^ b[W-1];
            f_nan  = cls[0].is_nan || cls[1].is_nan
                  || (cls[0].is_zero && cls[1].is_inf)
                  || (cls[0].is_inf && cls[1].is_zero);
            f_inf  = cls[0].is_inf || cls[1].is_inf;
            f_zero = cls[0].is_zero || cls[1].is_zero;
            e_fin  = e_mul;
            f_fin  = frac_m;
        end
    end

    always_comb begin
        if (f_nan) begin
            res = QNAN;
        end else if (f_inf) begin
            res = {s_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else if (f_zero || (e_fin <= 0)) begin
            res = {s_res, {(W-1){1'b0}}};
        end else if (e_fin >= TOP_C) begin
            res = {s_res, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
        end else begin
            res = {s_res, e_fin[EXP_W-1:0], f_fin};
        end
    end
endmodule

// File: rtl/sfm_ctrl.sv
module sfm_ctrl
    import sfm_pkg::*;
#(
    parameter int LATENCY = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic load_stage,
    output logic load_res,
    output logic done
);
    localparam bit TWO_STEP = (LATENCY == 2);

    sfm_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE: begin
                if (start) begin
                    state_d = TWO_STEP ? S_HOLD : S_DONE;
                end else begin
                    state_d = S_IDLE;
                end
            end
            S_HOLD:  state_d = S_DONE;
            default: state_d = S_IDLE;
        endcase
    end

    always_comb begin
        accept     = start && (state_q != S_HOLD);
        load_stage = TWO_STEP && accept;
        load_res   = TWO_STEP ? (state_q == S_HOLD) : accept;
        done       = (state_q == S_DONE);
    end
endmodule

// File: rtl/sfmul_unit.sv
module sfmul_unit
    import sfm_pkg::*;
#(
    parameter int FRAC_W  = 10,
    parameter int LATENCY = 2,
    parameter int SH_W    = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [1:0]             op,
    input  logic [FRAC_W+EXP_W:0]  a,
    input  logic [FRAC_W+EXP_W:0]  b,
    input  logic signed [SH_W-1:0] shamt,
    output logic                   done,
    output logic [FRAC_W+EXP_W:0]  result
);
    localparam int W = FRAC_W + EXP_W + 1;

    logic accept, load_stage, load_res;

    sfm_ctrl #(.LATENCY(LATENCY)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .accept     (accept),
        .load_stage (load_stage),
        .load_res   (load_res),
        .done       (done)
    );

    logic [1:0]             dp_op;
    logic [W-1:0]           dp_a, dp_b;
    logic signed [SH_W-1:0] dp_sh;
    logic [W-1:0]           dp_res;

    if (LATENCY == 2) begin : g_stage
        logic [1:0]             op_q;
        logic [W-1:0]           a_q, b_q;
        logic signed [SH_W-1:0] sh_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                op_q <= '0;
                a_q  <= '0;
                b_q  <= '0;
                sh_q <= '0;
            end else if (load_stage) begin
                op_q <= op;
                a_q  <= a;
                b_q  <= b;
                sh_q <= shamt;
            end
        end

        assign dp_op = op_q;
        assign dp_a  = a_q;
        assign dp_b  = b_q;
        assign dp_sh = sh_q;
    end else begin : g_direct
        assign dp_op = op;
        assign dp_a  = a;
        assign dp_b  = b;
        assign dp_sh = shamt;
    end

    sfm_datapath #(.FRAC_W(FRAC_W), .SH_W(SH_W)) u_dp (
        .op    (dp_op),
        .a     (dp_a),
        .b     (dp_b),
        .shamt (dp_sh),
        .res   (dp_res)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
        end else if (load_res) begin
            result <= dp_res;
        end
    end
endmodule

// File: rtl/sfmul_unit_chk.sv
module sfmul_unit_chk
    import sfm_pkg::*;
#(
    parameter int FRAC_W  = 10,
    parameter int LATENCY = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  accept,
    input logic                  done,
    input logic [FRAC_W+EXP_W:0] result
);
    localparam int W = FRAC_W + EXP_W + 1;
    localparam logic [W-1:0] QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

    logic [EXP_W-1:0]  r_exp;
    logic [FRAC_W-1:0] r_frac;
    assign r_exp  = result[FRAC_W +: EXP_W];
    assign r_frac = result[FRAC_W-1:0];

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(result) |-> done);

    p_nan_canon_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && (r_exp == '1) && (r_frac != '0)) |-> (result == QNAN));

    p_no_subnormal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !((r_exp == '0) && (r_frac != '0)));

    p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !accept) |=> !done);

    if (LATENCY == 2) begin : g_two
        p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !done ##1 done);
        p_single_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> !accept);
    end else begin : g_one
        p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
            accept |=> done);
    end
endmodule

bind sfmul_unit sfmul_unit_chk #(.FRAC_W(FRAC_W), .LATENCY(LATENCY)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .accept (accept),
    .done   (done),
    .result (result)
);

// File: tb/test_sfmul_unit.sv
`timescale 1ns/1ps
module test_sfmul_unit;
    localparam real CLK_P = 4.0;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_P/2) clk = ~clk;

    // main unit: FRAC_W=10, LATENCY=2
    logic              start = 1'b0;
    logic [1:0]        op = '0;
    logic [15:0]       a = '0, b = '0;
    logic signed [5:0] shamt = '0;
    logic              done;
    logic [15:0]       result;

    sfmul_unit i_sfmul_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .a(a), .b(b),
        .shamt(shamt), .done(done), .result(result)
    );

    // second unit: FRAC_W=7, LATENCY=1
    logic              start2 = 1'b0;
    logic [1:0]        op2 = '0;
    logic [12:0]       a2 = '0, b2 = '0;
    logic signed [5:0] sh2 = '0;
    logic              done2;
    logic [12:0]       res2;

    sfmul_unit #(.FRAC_W(7), .LATENCY(1)) i_sfmul_unit_fast (
        .clk(clk), .rst_n(rst_n), .start(start2), .op(op2), .a(a2), .b(b2),
        .shamt(sh2), .done(done2), .result(res2)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [15:0] exp_q[$];
    string       tag_q[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, expv);
        end
    endtask

    // reference built from the requirements, FRAC_W = 10
    function automatic logic [15:0] model(input logic [1:0] o, input logic [15:0] x,
                                          input logic [15:0] y, input int n);
        int ex = int'(x[14:10]);
        int ey = int'(y[14:10]);
        logic [9:0] fx = x[9:0];
        logic [9:0] fy = y[9:0];
        bit zx = (ex == 0), zy = (ey == 0);
        bit ix = (ex == 31) && (fx == 0), iy = (ey == 31) && (fy == 0);
        bit nx = (ex == 31) && (fx != 0), ny = (ey == 31) && (fy != 0);
        logic s;
        int e;
        logic [9:0] f;
        longint p;
        if (o == 2'd1 || o == 2'd2) begin
            if (nx) return 16'h7E00;
            s = x[15];
            if (ix) return {s, 15'h7C00};
            if (zx) return {s, 15'h0000};
            e = (o == 2'd1) ? ex + n : ex - n;
            f = fx;
        end else begin
            s = x[15] ^ y[15];
            if (nx || ny || (zx && iy) || (ix && zy)) return 16'h7E00;
            if (ix || iy) return {s, 15'h7C00};
            if (zx || zy) return {s, 15'h0000};
            p = longint'(1024 + fx) * longint'(1024 + fy);
            if (p >= 64'd2097152) begin
                e = ex + ey - 14;
                f = 10'((p >> 11) & 1023);
            end else begin
                e = ex + ey - 15;
                f = 10'((p >> 10) & 1023);
            end
        end
        if (e <= 0)  return {s, 15'h0000};
        if (e >= 31) return {s, 15'h7C00};
        return {s, 5'(e), f};
    endfunction

    // driver: called at a falling edge, returns two falling edges later
    task automatic issue(input logic [1:0] o, input logic [15:0] x, input logic [15:0] y,
                         input int n, input string tag);
        start = 1'b1; op = o; a = x; b = y; shamt = 6'(n);
        exp_q.push_back(model(o, x, y, n));
        tag_q.push_back(tag);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R3: actual unexpected done (result %h) expected no done", result);
            end else begin
                check(tag_q.pop_front(), {16'h0, result}, {16'h0, exp_q.pop_front()});
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R11 reset done", {31'h0, done}, 32'h0);
        check("R11 reset result", {16'h0, result}, 32'h0);
        check("R11 reset done fast", {31'h0, done2}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 normal multiplies
        issue(2'd0, 16'h3E00, 16'h3E00, 0, "R4 1.5*1.5");
        issue(2'd0, 16'h3C01, 16'h3C01, 0, "R4 truncation");
        issue(2'd0, 16'h3FFF, 16'h3FFF, 0, "R4 product above 2");
        issue(2'd0, 16'hC000, 16'h4200, 0, "R4 sign xor");
        issue(2'd3, 16'h4000, 16'h4200, 0, "R1 opcode 3 multiplies");
        // R5 zeros and subnormal inputs
        issue(2'd0, 16'h0001, 16'h3C00, 0, "R5 subnormal as zero");
        issue(2'd0, 16'h8000, 16'h4000, 0, "R5 signed zero");
        // R6 infinity and overflow
        issue(2'd0, 16'h7C00, 16'hC000, 0, "R6 inf times neg");
        issue(2'd0, 16'h7BFF, 16'h4000, 0, "R6 overflow");
        // R7 underflow
        issue(2'd0, 16'h0400, 16'h3800, 0, "R7 underflow");
        issue(2'd0, 16'h8400, 16'h3800, 0, "R7 negative underflow");
        // R8 NaN cases
        issue(2'd0, 16'hFC01, 16'h3C00, 0, "R8 nan input");
        issue(2'd0, 16'h0000, 16'h7C00, 0, "R8 zero times inf");
        issue(2'd0, 16'h3C00, 16'h7E55, 0, "R8 nan second operand");
        // R9 scaling
        issue(2'd1, 16'h3C00, 16'h0000, 3, "R9 scale up");
        issue(2'd2, 16'h3C00, 16'h0000, 3, "R9 scale down");
        issue(2'd1, 16'hBE00, 16'h0000, -2, "R9 negative count");
        issue(2'd2, 16'h7800, 16'h0000, -20, "R9 overflow to inf");
        issue(2'd2, 16'h8400, 16'h0000, 1, "R9 underflow to zero");
        issue(2'd1, 16'h0000, 16'h0000, 31, "R9 zero passes");
        issue(2'd2, 16'hFC00, 16'h0000, 5, "R9 inf passes");
        issue(2'd1, 16'h7D00, 16'h0000, 1, "R9 nan canonical");

        // R3: start during the middle cycle is ignored
        start = 1'b1; op = 2'd0; a = 16'h4000; b = 16'h4000; shamt = '0;
        exp_q.push_back(model(2'd0, 16'h4000, 16'h4000, 0));
        tag_q.push_back("R3 first job");
        @(negedge clk);
        op = 2'd0; a = 16'h4800; b = 16'h4800;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        check("R3 no second done", {31'h0, done}, 32'h0);
        check("R10 result held", {16'h0, result}, 32'h4400);

        // random sweep
        for (int i = 0; i < 300; i++) begin
            issue(2'($urandom_range(0, 2)), 16'($urandom), 16'($urandom),
                  int'($urandom_range(0, 15)) - 8, "R4 R9 sweep");
        end
        repeat (3) @(negedge clk);
        check("R2 queue drained", 32'(exp_q.size()), 32'h0);

        // one-cycle, 7-bit fraction unit
        start2 = 1'b1; op2 = 2'd0; a2 = 13'h07C0; b2 = 13'h07C0; sh2 = '0;
        @(negedge clk);
        check("R2 one-cycle done", {31'h0, done2}, 32'h1);
        check("R1 seven-bit product", {19'h0, res2}, 32'h0810);
        op2 = 2'd1; a2 = 13'h07C0; sh2 = 6'sd1;
        @(negedge clk);
        start2 = 1'b0;
        check("R2 back to back done", {31'h0, done2}, 32'h1);
        check("R9 seven-bit scale", {19'h0, res2}, 32'h0840);
        @(negedge clk);
        check("R2 single pulse", {31'h0, done2}, 32'h0);
        check("R10 fast result held", {19'h0, res2}, 32'h0840);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule